// File: doc/BRIEF.md
# Line Error Event Counter with Freeze and Per-Second Latch

This block counts line error events in a 16-bit running counter and presents the count to software through a small 8-bit register port. Software picks one of two modes with a mode bit.

In manual mode, software sets a freeze bit before it reads. The 0-to-1 transition of that bit copies the running count into a holding register and restarts the running count from zero. While the freeze bit stays set, the visible count is the held value, so it does not move. In automatic mode, a one-clock-wide once-per-second strobe does the same copy and restart. The strobe also raises a sticky interrupt flag, and software clears that flag by writing 1 to it. The held value then stays valid for a full interval.

A 16-bit value is read as two bytes, low byte first. The low-byte read also captures the matching high byte, so the following high-byte read is coherent with it.

Top module: `line_err_counter`

## Requirements
- R1: After reset, every register address reads 0 and `irq` is low.
- R2: Each clock cycle with `err_pulse` high adds one to the running count. This holds unless the cycle restarts the interval. In manual mode with freeze clear, the visible count is the running count.
- R3: The running count saturates at 0xFFFF and does not wrap.
- R4: In manual mode, a write that takes the freeze bit from 0 to 1 copies the running count into the holding register and clears the running count. While freeze stays 1, the visible count is the held value, even though error pulses keep arriving.
- R5: Clearing the freeze bit in manual mode makes the visible count the running count again. That count holds the events counted since the freeze edge.
- R6: In automatic mode, each `tick_1s` pulse copies the running count into the holding register and restarts the running count from zero. The visible count is always the held value.
- R7: An error pulse in the same cycle as a restart (tick or freeze edge) is counted into the new interval, so the running count becomes 1 and is not lost.
- R8: In automatic mode, `tick_1s` sets the sticky interrupt flag, which drives `irq` and reads as bit 0 of address 1. Writing 1 to that bit clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R9: In manual mode, `tick_1s` has no effect on the held value, the visible count or the interrupt flag.
- R10: A read of address 2 returns the low byte of the visible count and captures its high byte. A later read of address 3 returns that captured byte, even if the count has changed since.
- R11: The register map has four addresses. Address 0 holds the control bits, read/write: bit 0 is the mode (0 manual, 1 automatic) and bit 1 is freeze. Address 1 holds the status, with the flag in bit 0. Address 2 is the count low byte. Address 3 is the captured high byte.
- R12: Writing freeze = 1 while freeze is already 1 does not restart the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 1 | One line error event per high cycle |
| tick_1s | input | 1 | One-cycle once-per-second strobe |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (captures the high byte on address 2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Sticky one-second interrupt flag |

## Verification
Two pairs of events can fall in the same cycle.

- An error pulse can coincide with an interval restart, which comes from either the tick or the freeze edge. The bench drives `err_pulse` in the very cycle of `tick_1s`, and again in the cycle of the freeze write. It then judges the result from the counts read back afterwards: the held value must leave that pulse out, and the next interval must include it.
- The interrupt set can coincide with its write-1 clear. The bench issues both in one cycle and expects the flag to remain set.

// File: rtl/lec_pkg.sv
package lec_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STAT   = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_CNT_HI = 2'd3
  } lec_reg_e;

  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_FRZ_BIT  = 1;
  localparam int STAT_IRQ_BIT  = 0;
endpackage

// File: rtl/lec_live_cnt.sv
module lec_live_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_pulse,
  input  logic             restart,
  output logic [CNT_W-1:0] live_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // next running count: restart opens a new interval that already holds
  // a coincident pulse; otherwise saturating increment
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             pulse,
    input logic             new_ivl
  );
    if (new_ivl) return pulse ? CNT_W'(1) : '0;
    if (pulse && cur != CNT_MAX) return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) live_cnt <= '0;
    else        live_cnt <= next_count(live_cnt, err_pulse, restart);
  end
endmodule

// File: rtl/lec_hold.sv
module lec_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] live_cnt,
  output logic [CNT_W-1:0] hold_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)       hold_cnt <= '0;
    else if (restart) hold_cnt <= live_cnt;
  end
endmodule

// File: rtl/lec_regs.sv
module lec_regs
  import lec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              tick_1s,
  input  logic [CNT_W-1:0]  vis_cnt,
  output logic              mode_auto,
  output logic              frz,
  output logic              frz_edge,
  output logic              irq_set,
  output logic              irq,
  output logic [BYTE_W-1:0] hi_snap
);
  lec_reg_e reg_sel;
  logic     ctrl_wr, stat_clr, lo_rd;
  logic     unused_wbits;

  assign reg_sel  = lec_reg_e'(bus_addr);
  assign ctrl_wr  = bus_wr && reg_sel == REG_CTRL;
  assign stat_clr = bus_wr && reg_sel == REG_STAT && bus_wdata[STAT_IRQ_BIT];
  assign lo_rd    = bus_rd && reg_sel == REG_CNT_LO;

  // freeze edge counts only in manual mode, judged on the current mode
  assign frz_edge = ctrl_wr && bus_wdata[CTRL_FRZ_BIT] && !frz && !mode_auto;
  assign irq_set  = tick_1s && mode_auto;

  assign unused_wbits = ^bus_wdata[BYTE_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_auto <= 1'b0;
      frz       <= 1'b0;
      irq       <= 1'b0;
      hi_snap   <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_auto <= bus_wdata[CTRL_MODE_BIT];
        frz       <= bus_wdata[CTRL_FRZ_BIT];
      end
      irq <= irq_set | (irq & ~stat_clr);
      if (lo_rd) hi_snap <= vis_cnt[CNT_W-1:BYTE_W];
    end
  end

  always_comb begin
    unique case (reg_sel)
      REG_CTRL:   bus_rdata = {{(BYTE_W-2){1'b0}}, frz, mode_auto};
      REG_STAT:   bus_rdata = {{(BYTE_W-1){1'b0}}, irq};
      REG_CNT_LO: bus_rdata = vis_cnt[BYTE_W-1:0];
      default:    bus_rdata = hi_snap;
    endcase
  end
endmodule

// File: rtl/line_err_counter.sv
module line_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_pulse,
  input  logic               tick_1s,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [CNT_W/2-1:0] bus_wdata,
  output logic [CNT_W/2-1:0] bus_rdata,
  output logic               irq
);
  localparam int BYTE_W = CNT_W / 2;

  logic [CNT_W-1:0]  live_cnt, hold_cnt, vis_cnt;
  logic [BYTE_W-1:0] hi_snap;
  logic              mode_auto, frz, frz_edge, irq_set, restart_evt;

  // one restart event serves both modes: latch-and-clear
  assign restart_evt = irq_set | frz_edge;
  assign vis_cnt     = (mode_auto || frz) ? hold_cnt : live_cnt;

  lec_live_cnt #(.CNT_W(CNT_W)) u_live (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse),
    .restart(restart_evt), .live_cnt(live_cnt)
  );

  lec_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .restart(restart_evt),
    .live_cnt(live_cnt), .hold_cnt(hold_cnt)
  );

  lec_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_1s(tick_1s), .vis_cnt(vis_cnt),
    .mode_auto(mode_auto), .frz(frz), .frz_edge(frz_edge),
    .irq_set(irq_set), .irq(irq), .hi_snap(hi_snap)
  );
endmodule

// File: rtl/lec_chk.sv
module lec_chk #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = CNT_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_pulse,
  input logic              tick_1s,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic              irq,
  input logic              restart,
  input logic              mode_auto,
  input logic              frz,
  input logic [CNT_W-1:0]  live_cnt,
  input logic [CNT_W-1:0]  hold_cnt,
  input logic [CNT_W-1:0]  vis_cnt,
  input logic [BYTE_W-1:0] hi_snap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && err_pulse && live_cnt != CNT_MAX) |=> live_cnt == CNT_W'($past(live_cnt) + 1'b1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == CNT_MAX && !restart) |=> live_cnt == CNT_MAX);

  assert_frozen_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !mode_auto && !bus_wr && !tick_1s) |=> $stable(vis_cnt));

  assert_latch_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> hold_cnt == $past(live_cnt));

  assert_pulse_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && err_pulse) |=> live_cnt == CNT_W'(1));

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_auto && tick_1s) |=> irq);

  assert_manual_tick_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_auto && tick_1s && !bus_wr) |=> ($stable(hold_cnt) && irq == $past(irq)));

  assert_hi_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2) |=> hi_snap == $past(vis_cnt[CNT_W-1:BYTE_W]));
endmodule

bind line_err_counter lec_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .tick_1s(tick_1s),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .irq(irq),
  .restart(restart_evt), .mode_auto(mode_auto), .frz(frz),
  .live_cnt(live_cnt), .hold_cnt(hold_cnt), .vis_cnt(vis_cnt), .hi_snap(hi_snap)
);

// File: tb/line_err_counter_tb.sv
`timescale 1ns/1ps
module line_err_counter_tb;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PULSE = 2'd2, OP_TICK = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [16:0] arg;   // write data or pulse count
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [0:NV-1] = '{
    '{OP_PULSE, 2'd0, 17'd5,   8'h00, 4'd2},   // R2 five events
    '{OP_RD,    2'd2, 17'd0,   8'h05, 4'd2},   // R2 low byte
    '{OP_RD,    2'd3, 17'd0,   8'h00, 4'd10},  // R10 high byte
    '{OP_WR,    2'd0, 17'h02,  8'h00, 4'd4},   // R4 freeze edge
    '{OP_PULSE, 2'd0, 17'd3,   8'h00, 4'd4},   // R4 events while frozen
    '{OP_RD,    2'd2, 17'd0,   8'h05, 4'd4},   // R4 held value
    '{OP_WR,    2'd0, 17'h02,  8'h00, 4'd12},  // R12 freeze again, no edge
    '{OP_RD,    2'd2, 17'd0,   8'h05, 4'd12},  // R12 unchanged
    '{OP_WR,    2'd0, 17'h00,  8'h00, 4'd5},   // R5 unfreeze
    '{OP_RD,    2'd2, 17'd0,   8'h03, 4'd5},   // R5 running count
    '{OP_TICK,  2'd0, 17'd0,   8'h00, 4'd9},   // R9 tick in manual
    '{OP_RD,    2'd1, 17'd0,   8'h00, 4'd9},   // R9 no flag
    '{OP_RD,    2'd2, 17'd0,   8'h03, 4'd9},   // R9 count intact
    '{OP_WR,    2'd0, 17'h01,  8'h00, 4'd6},   // R6 automatic mode
    '{OP_RD,    2'd2, 17'd0,   8'h05, 4'd6},   // R6 shows held value
    '{OP_PULSE, 2'd0, 17'd7,   8'h00, 4'd6},
    '{OP_TICK,  2'd0, 17'd0,   8'h00, 4'd6},
    '{OP_RD,    2'd2, 17'd0,   8'h0A, 4'd6},   // R6 latched 10
    '{OP_RD,    2'd1, 17'd0,   8'h01, 4'd8},   // R8 flag set
    '{OP_WR,    2'd1, 17'h01,  8'h00, 4'd8},   // R8 write-1 clear
    '{OP_RD,    2'd1, 17'd0,   8'h00, 4'd8},   // R8 cleared
    '{OP_RD,    2'd0, 17'd0,   8'h01, 4'd11},  // R11 control readback
    '{OP_PULSE, 2'd0, 17'd300, 8'h00, 4'd10},
    '{OP_TICK,  2'd0, 17'd0,   8'h00, 4'd10},
    '{OP_RD,    2'd2, 17'd0,   8'h2C, 4'd10},  // R10 0x012C low
    '{OP_RD,    2'd3, 17'd0,   8'h01, 4'd10}   // R10 0x012C high
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_pulse = 1'b0, tick_1s = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  line_err_counter u_dut (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .tick_1s(tick_1s),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input int req);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, bus_rdata, exp, "register read");
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulses(input int n);
    err_pulse = 1'b1;
    repeat (n) @(negedge clk);
    err_pulse = 1'b0;
  endtask

  task automatic tick(input logic with_pulse);
    tick_1s = 1'b1; err_pulse = with_pulse;
    @(negedge clk);
    tick_1s = 1'b0; err_pulse = 1'b0;
  endtask

  task automatic apply_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); #1;
      check(1, bus_rdata, 8'h00, "reset register value");   // R1
    end
    check(1, {7'd0, irq}, 8'h00, "reset irq");              // R1
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    summary();
  end

  initial begin
    @(negedge clk);
    apply_reset();                                   // R1

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR:    wr(VEC[i].addr, VEC[i].arg[7:0]);
        OP_RD:    rd(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
        OP_PULSE: pulses(int'(VEC[i].arg));
        default:  tick(1'b0);
      endcase
    end

    // R7 automatic: pulse coincident with the tick joins the new interval
    pulses(4);
    tick(1'b1);
    rd(2'd2, 8'h04, 7);                              // R7 held excludes it
    pulses(2);
    tick(1'b0);
    rd(2'd2, 8'h03, 7);                              // R7 1 + 2

    // R8 set and clear in the same cycle: set wins
    wr(2'd1, 8'h01);
    rd(2'd1, 8'h00, 8);                              // R8
    bus_addr = 2'd1; bus_wdata = 8'h01; bus_wr = 1'b1; tick_1s = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_1s = 1'b0;
    check(8, {7'd0, irq}, 8'h01, "irq after set+clear");   // R8
    wr(2'd1, 8'h01);
    check(8, {7'd0, irq}, 8'h00, "irq after clear");       // R8

    // R7 manual: pulse coincident with the freeze edge
    wr(2'd0, 8'h00);
    pulses(2);
    bus_addr = 2'd0; bus_wdata = 8'h02; bus_wr = 1'b1; err_pulse = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; err_pulse = 1'b0;
    rd(2'd2, 8'h02, 4);                              // R4 held value
    wr(2'd0, 8'h00);
    rd(2'd2, 8'h01, 7);                              // R7 pulse kept

    // R10 coherence across a byte carry
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h00);
    pulses(255);
    rd(2'd2, 8'hFF, 10);                             // R10
    pulses(1);
    rd(2'd3, 8'h00, 10);                             // R10 snapshot, not 0x01
    rd(2'd2, 8'h00, 10);                             // R10
    rd(2'd3, 8'h01, 10);                             // R10

    // R3 saturation
    wr(2'd0, 8'h01);
    tick(1'b0);
    pulses(65540);
    tick(1'b0);
    rd(2'd2, 8'hFF, 3);                              // R3
    rd(2'd3, 8'hFF, 3);                              // R3

    // R1 reset in the middle of operation
    @(negedge clk);
    apply_reset();

    summary();
  end
endmodule